// File: doc/BRIEF.md
# Tagged Translation Buffer with Random Refill Slot

This block caches recently used translations from 4 KB virtual pages to physical page numbers. Every stored entry carries an address space tag. Processes that share the buffer therefore keep their translations apart without a flush at each process switch. An entry can be marked global, and a global entry serves every address space. A lookup presents a virtual address, the current address space tag and a load/store flag. One clock later the block answers with exactly one of three results: hit, miss or write-protect fault. A hit also carries the physical address.

Entries are installed through a single write port by a refill walker or by privileged software. The target slot is either an explicit index or the value of a free-running slot counter. That counter steps down by one every cycle and covers only the upper, non-reserved part of the array. The lowest slots are therefore never chosen at random and can hold pinned translations. Two flush commands remove stale entries. One clears the whole array. The other clears every non-global entry that belongs to one address space tag.

The block has no state machine. The only sequential elements are the per-slot valid flags, the entry data, the slot counter and the registered response.

Top module: `tlb_asid`

## Requirements
- R1: On a hit, `rsp_paddr` is the entry's 20-bit physical page number placed above virtual address bits [11:0], which pass through unchanged.
- R2: Every one of the 64 slots is compared in parallel, and an entry written to any slot is found by a lookup of its page number and tag.
- R3: A lookup that matches no valid entry gives `rsp_miss`=1, `rsp_hit`=0 and `rsp_paddr`=0. An entry written with its valid bit at 0 never matches.
- R4: A non-global entry matches only when its stored 8-bit tag equals `lk_asid`.
- R5: An entry written with `wr_global`=1 matches whatever value `lk_asid` has.
- R6: `rand_slot` is 63 after reset. It decrements by one on every clock and goes from 8 back to 63, so it never shows a value below 8.
- R7: When `wr_use_random`=1, the entry goes to the slot shown on `rand_slot` in the cycle of the write. Otherwise it goes to the slot given by `wr_index`. The new entry replaces whatever that slot held.
- R8: A store lookup (`lk_store`=1) that matches an entry whose writable bit is 0 gives `rsp_wp_fault`=1 with `rsp_hit`=0. A load lookup that matches the same entry is a hit.
- R9: When two or more entries match, the lowest-index one supplies the translation and `rsp_multi`=1. Otherwise `rsp_multi`=0.
- R10: `flush_all` invalidates every entry at the next clock.
- R11: `flush_asid_en` invalidates every non-global entry whose tag equals `flush_asid`. Global entries and entries with other tags are kept.
- R12: After reset, all entries are invalid and all response outputs are 0.
- R13: `rsp_valid` is 1 exactly one cycle after a cycle with `lk_valid`=1. In that cycle, exactly one of hit, miss and fault is set. When `rsp_valid` is 0, none of them is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Current address space tag |
| lk_store | input | 1 | 1 = store access, 0 = load |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Translation found and access allowed |
| rsp_miss | output | 1 | No valid matching entry |
| rsp_wp_fault | output | 1 | Store to a non-writable page |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_paddr | output | 32 | Translated physical address |
| wr_en | input | 1 | Install an entry |
| wr_use_random | input | 1 | 1 = use `rand_slot`, 0 = use `wr_index` |
| wr_index | input | 6 | Explicit target slot |
| wr_vpn | input | 20 | Virtual page number of the new entry |
| wr_asid | input | 8 | Address space tag of the new entry |
| wr_global | input | 1 | Entry matches all tags |
| wr_valid | input | 1 | Valid bit of the new entry |
| wr_writable | input | 1 | Stores are allowed to this page |
| wr_ppn | input | 20 | Physical page number of the new entry |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate the non-global entries of one tag |
| flush_asid | input | 8 | Tag to invalidate |
| rand_slot | output | 6 | Current random refill slot |

## Verification
On every cycle, the assertions check these properties:
- the counter stays inside the non-reserved range and follows its decrement-and-wrap rule;
- the three response kinds are mutually exclusive and follow `lk_valid` by exactly one cycle;
- the chosen slot is a real match with no lower match;
- a flush leaves no valid flag set.

The bench scenarios cover what no single-cycle property can show. They sweep all slots with distinct translations and prove that the right physical page comes back with the offset intact. They show that tags keep processes apart while global entries bypass the tag. They confirm that a random refill lands in the slot the counter predicted. They also check that each flush removes exactly the intended entries.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    parameter int VA_W     = 32;
    parameter int PA_W     = 32;
    parameter int PG_OFF_W = 12;
    parameter int ASID_W   = 8;
    localparam int VPN_W   = VA_W - PG_OFF_W;
    localparam int PPN_W   = PA_W - PG_OFF_W;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              writable;
        logic [PPN_W-1:0]  ppn;
    } tlb_ent_t;
endpackage

// File: rtl/tlb_rand_slot.sv
module tlb_rand_slot #(
    parameter int N_ENTRIES = 64,
    parameter int N_WIRED   = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [IDX_W-1:0] slot
);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(N_ENTRIES - 1);
    localparam logic [IDX_W-1:0] LOW = IDX_W'(N_WIRED);

    always_ff @(posedge clk) begin
        if (rst)             slot <= TOP;
        else if (slot == LOW) slot <= TOP;
        else                 slot <= slot - 1'b1;
    end

    a_r6_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        (slot >= LOW) && (slot <= TOP));

    a_r6_slot_steps: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (slot == (($past(slot) == LOW) ? TOP : $past(slot) - 1'b1)));
endmodule

// File: rtl/tlb_array.sv
module tlb_array import tlbp_pkg::*; #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_slot,
    input  tlb_ent_t          wr_ent,
    input  logic              wr_valid,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output tlb_ent_t          ent_q [N_ENTRIES],
    output logic [N_ENTRIES-1:0] vld_q
);
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_slot
        logic sel_wr;
        logic kill;
        assign sel_wr = wr_en && (wr_slot == IDX_W'(i));
        assign kill   = flush_all ||
                        (flush_asid_en && !ent_q[i].glob && (ent_q[i].asid == flush_asid));

        always_ff @(posedge clk) begin
            if (rst)         vld_q[i] <= 1'b0;
            else if (sel_wr) vld_q[i] <= wr_valid;
            else if (kill)   vld_q[i] <= 1'b0;
        end

        always_ff @(posedge clk) begin
            if (sel_wr) ent_q[i] <= wr_ent;
        end
    end

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (rst)
        (flush_all && !wr_en) |=> (vld_q == '0));

    a_r12_reset_empty: assert property (@(posedge clk)
        rst |=> (vld_q == '0));
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup import tlbp_pkg::*; #(
    parameter int N_ENTRIES = 64,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  tlb_ent_t             ent_q [N_ENTRIES],
    input  logic [N_ENTRIES-1:0] vld_q,
    input  logic [VPN_W-1:0]     vpn,
    input  logic [ASID_W-1:0]    asid,
    output logic                 any_match,
    output logic                 multi,
    output logic [IDX_W-1:0]     sel_idx,
    output tlb_ent_t             sel_ent
);
    logic [N_ENTRIES-1:0] match_vec;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = vld_q[i] && (ent_q[i].vpn == vpn) &&
                              (ent_q[i].glob || (ent_q[i].asid == asid));
    end

    always_comb begin
        sel_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) sel_idx = IDX_W'(i);
        end
    end

    assign any_match = |match_vec;
    assign multi     = |(match_vec & (match_vec - 1'b1));
    assign sel_ent   = ent_q[sel_idx];

    always_comb begin
        if (any_match) begin
            a_r9_sel_is_match: assert (match_vec[sel_idx]);
            a_r9_none_below: assert ((match_vec & ((N_ENTRIES'(1) << sel_idx) - 1'b1)) == '0);
        end
    end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid import tlbp_pkg::*; #(
    parameter int N_ENTRIES = 64,
    parameter int N_WIRED   = 8,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_store,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_miss,
    output logic              rsp_wp_fault,
    output logic              rsp_multi,
    output logic [PA_W-1:0]   rsp_paddr,
    input  logic              wr_en,
    input  logic              wr_use_random,
    input  logic [IDX_W-1:0]  wr_index,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_global,
    input  logic              wr_valid,
    input  logic              wr_writable,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    output logic [IDX_W-1:0]  rand_slot
);
    tlb_ent_t             ent_q [N_ENTRIES];
    logic [N_ENTRIES-1:0] vld_q;
    tlb_ent_t             wr_ent;
    logic [IDX_W-1:0]     wr_slot;
    logic                 any_match;
    logic                 multi;
    logic [IDX_W-1:0]     sel_idx;
    tlb_ent_t             sel_ent;
    logic                 deny;

    tlb_rand_slot #(.N_ENTRIES(N_ENTRIES), .N_WIRED(N_WIRED)) u_rand (
        .clk (clk),
        .rst (rst),
        .slot(rand_slot)
    );

    assign wr_slot = wr_use_random ? rand_slot : wr_index;
    assign wr_ent  = '{vpn: wr_vpn, asid: wr_asid, glob: wr_global,
                       writable: wr_writable, ppn: wr_ppn};

    tlb_array #(.N_ENTRIES(N_ENTRIES)) u_array (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_slot      (wr_slot),
        .wr_ent       (wr_ent),
        .wr_valid     (wr_valid),
        .flush_all    (flush_all),
        .flush_asid_en(flush_asid_en),
        .flush_asid   (flush_asid),
        .ent_q        (ent_q),
        .vld_q        (vld_q)
    );

    tlb_lookup #(.N_ENTRIES(N_ENTRIES)) u_lookup (
        .ent_q    (ent_q),
        .vld_q    (vld_q),
        .vpn      (lk_vaddr[VA_W-1:PG_OFF_W]),
        .asid     (lk_asid),
        .any_match(any_match),
        .multi    (multi),
        .sel_idx  (sel_idx),
        .sel_ent  (sel_ent)
    );

    assign deny = lk_store && !sel_ent.writable;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_hit      <= 1'b0;
            rsp_miss     <= 1'b0;
            rsp_wp_fault <= 1'b0;
            rsp_multi    <= 1'b0;
            rsp_paddr    <= '0;
        end else begin
            rsp_valid    <= lk_valid;
            rsp_hit      <= lk_valid && any_match && !deny;
            rsp_miss     <= lk_valid && !any_match;
            rsp_wp_fault <= lk_valid && any_match && deny;
            rsp_multi    <= lk_valid && multi;
            rsp_paddr    <= (lk_valid && any_match)
                            ? {sel_ent.ppn, lk_vaddr[PG_OFF_W-1:0]} : '0;
        end
    end

    a_r13_follows_req: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> rsp_valid);
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> !rsp_valid && !rsp_hit && !rsp_miss && !rsp_wp_fault);
    a_r13_one_kind: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_wp_fault}) == 1);
    a_r9_multi_not_miss: assert property (@(posedge clk) disable iff (rst)
        rsp_multi |-> !rsp_miss);
    a_r3_miss_zero_addr: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (rsp_paddr == '0));
    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && any_match) |=> (rsp_paddr[PG_OFF_W-1:0] == $past(lk_vaddr[PG_OFF_W-1:0])));
endmodule

// File: tb/tlb_asid_tb.sv
module tlb_asid_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        lk_valid, lk_store;
    logic [31:0] lk_vaddr;
    logic [7:0]  lk_asid;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_wp_fault, rsp_multi;
    logic [31:0] rsp_paddr;
    logic        wr_en, wr_use_random, wr_global, wr_valid, wr_writable;
    logic [5:0]  wr_index;
    logic [19:0] wr_vpn, wr_ppn;
    logic [7:0]  wr_asid, flush_asid;
    logic        flush_all, flush_asid_en;
    logic [5:0]  rand_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    bit rchk_en = 1'b0;
    int rmodel;

    always #4 clk = ~clk;

    tlb_asid u_dut (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_asid(lk_asid), .lk_store(lk_store), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_wp_fault(rsp_wp_fault),
        .rsp_multi(rsp_multi), .rsp_paddr(rsp_paddr), .wr_en(wr_en),
        .wr_use_random(wr_use_random), .wr_index(wr_index), .wr_vpn(wr_vpn),
        .wr_asid(wr_asid), .wr_global(wr_global), .wr_valid(wr_valid),
        .wr_writable(wr_writable), .wr_ppn(wr_ppn), .flush_all(flush_all),
        .flush_asid_en(flush_asid_en), .flush_asid(flush_asid), .rand_slot(rand_slot)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Independent model of the slot counter: 63 after reset, down by one, 8 -> 63.
    always @(posedge clk) begin
        if (rst) rmodel <= 63;
        else     rmodel <= (rmodel == 8) ? 63 : rmodel - 1;
    end

    always @(negedge clk) begin
        if (rchk_en) chk(rand_slot == 6'(rmodel), "R6", "rand_slot", 64'(rand_slot), 64'(rmodel));
    end

    task automatic do_write(input bit use_rnd, input int idx, input logic [19:0] vpn,
                            input logic [7:0] asid, input bit g, input bit v,
                            input bit w, input logic [19:0] ppn);
        wr_en = 1'b1; wr_use_random = use_rnd; wr_index = 6'(idx);
        wr_vpn = vpn; wr_asid = asid; wr_global = g; wr_valid = v;
        wr_writable = w; wr_ppn = ppn;
        @(negedge clk);
        wr_en = 1'b0; wr_use_random = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] va, input logic [7:0] asid, input bit st);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
        @(negedge clk);
        lk_valid = 1'b0; lk_store = 1'b0;
    endtask

    task automatic expect_hit(input string req, input logic [31:0] va, input logic [7:0] asid,
                              input bit st, input logic [19:0] ppn, input bit mult);
        logic [31:0] exp_pa;
        exp_pa = {ppn, va[11:0]};
        do_lookup(va, asid, st);
        chk(rsp_valid && rsp_hit && !rsp_miss && !rsp_wp_fault, req, "hit flags",
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_wp_fault}), 64'b1100);
        chk(rsp_paddr == exp_pa, req, "paddr", 64'(rsp_paddr), 64'(exp_pa));
        chk(rsp_multi == mult, req, "multi", 64'(rsp_multi), 64'(mult));
    endtask

    task automatic expect_miss(input string req, input logic [31:0] va, input logic [7:0] asid);
        do_lookup(va, asid, 1'b0);
        chk(rsp_valid && !rsp_hit && rsp_miss && !rsp_wp_fault && rsp_paddr == 0, req,
            "miss flags", 64'({rsp_valid, rsp_hit, rsp_miss, rsp_wp_fault}), 64'b1010);
    endtask

    task automatic expect_wp(input string req, input logic [31:0] va, input logic [7:0] asid);
        do_lookup(va, asid, 1'b1);
        chk(rsp_valid && !rsp_hit && !rsp_miss && rsp_wp_fault, req, "fault flags",
            64'({rsp_valid, rsp_hit, rsp_miss, rsp_wp_fault}), 64'b1001);
    endtask

    initial begin
        rst = 1'b1; lk_valid = 0; lk_store = 0; lk_vaddr = 0; lk_asid = 0;
        wr_en = 0; wr_use_random = 0; wr_index = 0; wr_vpn = 0; wr_asid = 0;
        wr_global = 0; wr_valid = 0; wr_writable = 0; wr_ppn = 0;
        flush_all = 0; flush_asid_en = 0; flush_asid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_wp_fault && !rsp_multi && rsp_paddr == 0,
            "R12", "reset outputs", 64'(rsp_paddr), 64'h0);
        rchk_en = 1'b1;
        expect_miss("R12", 32'h0010_0123, 8'h10);

        // R2/R1/R4/R8: sweep all slots with distinct translations
        for (int i = 0; i < 64; i++)
            do_write(1'b0, i, 20'h100 + 20'(i), 8'h10 + 8'(i), 1'b0, 1'b1, i[0],
                     20'h8000 + 20'(i * 3));
        for (int i = 0; i < 64; i++) begin
            logic [31:0] va;
            va = {20'h100 + 20'(i), 12'((i * 67) & 12'hfff)};
            expect_hit("R2", va, 8'h10 + 8'(i), 1'b0, 20'h8000 + 20'(i * 3), 1'b0);
            expect_miss("R4", va, 8'h11 + 8'(i));
            if (i[0]) expect_hit("R8", va, 8'h10 + 8'(i), 1'b1, 20'h8000 + 20'(i * 3), 1'b0);
            else      expect_wp("R8", va, 8'h10 + 8'(i));
        end
        // R13: no response without request
        @(negedge clk);
        chk(!rsp_valid && !rsp_hit && !rsp_miss && !rsp_wp_fault, "R13", "idle response",
            64'(rsp_valid), 64'h0);

        // R3: entry written invalid never matches
        do_write(1'b0, 0, 20'h100, 8'h10, 1'b0, 1'b0, 1'b1, 20'h1);
        expect_miss("R3", 32'h0010_0fff, 8'h10);

        // R5: global entry ignores the tag
        do_write(1'b0, 1, 20'h200, 8'h55, 1'b1, 1'b1, 1'b1, 20'h1234);
        expect_hit("R5", 32'h0020_0abc, 8'h99, 1'b0, 20'h1234, 1'b0);
        expect_hit("R5", 32'h0020_0001, 8'h55, 1'b1, 20'h1234, 1'b0);

        // R9: duplicate match takes the lowest index
        do_write(1'b0, 30, 20'h300, 8'h07, 1'b0, 1'b1, 1'b1, 20'h0aaa);
        do_write(1'b0, 12, 20'h300, 8'h07, 1'b0, 1'b1, 1'b1, 20'h0bbb);
        expect_hit("R9", 32'h0030_0444, 8'h07, 1'b0, 20'h0bbb, 1'b1);

        // R6/R7: random refill lands in the slot the counter shows
        repeat (130) @(negedge clk);
        begin
            int s;
            s = int'(rand_slot);
            chk(s >= 8, "R6", "slot above reserved", 64'(s), 64'd8);
            do_write(1'b1, 0, 20'h400, 8'h02, 1'b0, 1'b1, 1'b1, 20'h0777);
            expect_hit("R7", 32'h0040_0321, 8'h02, 1'b0, 20'h0777, 1'b0);
            do_write(1'b0, s, 20'h401, 8'h02, 1'b0, 1'b1, 1'b1, 20'h0778);
            expect_miss("R7", 32'h0040_0321, 8'h02);
            expect_hit("R7", 32'h0040_1321, 8'h02, 1'b0, 20'h0778, 1'b0);
        end

        // R11: per-tag flush
        do_write(1'b0, 2, 20'h500, 8'h03, 1'b0, 1'b1, 1'b1, 20'h0500);
        do_write(1'b0, 3, 20'h501, 8'h03, 1'b1, 1'b1, 1'b1, 20'h0501);
        do_write(1'b0, 4, 20'h502, 8'h04, 1'b0, 1'b1, 1'b1, 20'h0502);
        flush_asid_en = 1'b1; flush_asid = 8'h03;
        @(negedge clk);
        flush_asid_en = 1'b0;
        expect_miss("R11", 32'h0050_0000, 8'h03);
        expect_hit("R11", 32'h0050_1010, 8'h03, 1'b0, 20'h0501, 1'b0);
        expect_hit("R11", 32'h0050_2020, 8'h04, 1'b0, 20'h0502, 1'b0);

        // R10: full flush
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
        expect_miss("R10", 32'h0050_1010, 8'h03);
        expect_miss("R10", 32'h0050_2020, 8'h04);
        expect_miss("R10", 32'h0020_0abc, 8'h55);
        for (int i = 5; i < 64; i++)
            expect_miss("R10", {20'h100 + 20'(i), 12'h0}, 8'h10 + 8'(i));

        rchk_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule